// File: doc/BRIEF.md
# Paged Host Register Port

This block is the microprocessor-side front end of a peripheral. A host with a 16-bit, word-only bus reaches a 128 KB byte-addressed space through it. A region input picks the half of that space. With the input low, the host reaches a small internal register file. With the input high, it reaches a 64 KB window into external SRAM. A 5-bit page register in the register half selects which 64 KB page of a 2 MB SRAM the window shows.

The register file holds four kinds of storage:

- a plain control word;
- a group of sticky status flags that the host clears by writing ones;
- a read-only word supplied by internal logic;
- a group of write-only strobe bits that pulse toward internal logic and always read as zero.

Every access is a request/ready handshake. The host holds `hreq` and the access fields steady until `hready` pulses. On a read, `hrdata` is valid in that same cycle.

Top module: `host_page_regif`

## Requirements
- R1: With `hsel_ext` low, an access goes to the register file and `sram_req` stays low. With `hsel_ext` high, the access is forwarded on the SRAM request port.
- R2: The control word at byte address 0x0000 reads back the last value written to it, and `ctrl_out` carries that value.
- R3: A status flag at byte address 0x0002 (bit i follows `status_in[i]`) becomes 1 whenever its input is high, and it stays 1 after the input goes low.
- R4: Writing 1 to a status flag clears it only if its input is low in that cycle. Writing 0 leaves the flag unchanged.
- R5: Byte address 0x0004 reads the current `ro_in`. A write to it changes no register.
- R6: Writing a 1 to bit i at byte address 0x0006 drives `pulse_out[i]` high for exactly one cycle, in the cycle where `hready` is high. That address always reads 0.
- R7: The page register at byte address 0x0030 keeps the written bits [4:0] and reads them back in bits [4:0]. The upper read bits are zero.
- R8: A window access drives `sram_addr` = {page, `haddr[15:1]`}, `sram_we` = `hwe` and `sram_wdata` = `hwdata`. The access completes one cycle after `sram_ack`, and a read then returns the `sram_rdata` presented with the ack.
- R9: Register-half addresses other than 0x0000, 0x0002, 0x0004, 0x0006 and 0x0030 read zero, and writes to them change no register.
- R10: After reset, the control word, the status flags and the page register are zero, and `hready`, `pulse_out` and `sram_req` are low.
- R11: A register access completes with `hready` high one cycle after the request is first sampled. `hready` is high for one cycle per access, and `hrdata` is zero on write completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hreq | input | 1 | Host access request, held until `hready` |
| hsel_ext | input | 1 | Region select: 0 register file, 1 SRAM window |
| hwe | input | 1 | 1 write, 0 read |
| haddr | input | 15 | Word address, byte address bits [15:1] |
| hwdata | input | 16 | Write data |
| hrdata | output | 16 | Read data, valid with `hready` |
| hready | output | 1 | One-cycle completion pulse |
| status_in | input | 8 | Status event inputs |
| ro_in | input | 16 | Value shown at the read-only address |
| ctrl_out | output | 16 | Control word contents |
| pulse_out | output | 4 | One-cycle strobes |
| sram_req | output | 1 | SRAM request, held until `sram_ack` |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | 20 | SRAM word address (byte bits 20:1) |
| sram_wdata | output | 16 | SRAM write data |
| sram_rdata | input | 16 | SRAM read data, valid with `sram_ack` |
| sram_ack | input | 1 | SRAM completion |

## Verification
The bench writes 1 to a status flag while that flag's input is still high. A design that lets the write win would drop an event that is still active. It also writes 0 to a set flag, which a careless design would treat as a clear. A strobe write must give a single-cycle pulse and a zero read. A design that keeps strobe state would read back nonzero or hold the pulse for more than one cycle. Window accesses are made on two different pages, so a design that drops or misplaces the page bits sends the request to the wrong SRAM word. Writes to the read-only word and to a reserved address are followed by reads of the neighbouring registers, which exposes a decoder that aliases those addresses.

// File: rtl/host_page_regif.sv
module host_page_regif #(
  parameter int NSTAT = 8,
  parameter int NSTRB = 4,
  parameter int PAGEW = 5,
  localparam int SAW = PAGEW + 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hreq,
  input  logic             hsel_ext,
  input  logic             hwe,
  input  logic [15:1]      haddr,
  input  logic [15:0]      hwdata,
  output logic [15:0]      hrdata,
  output logic             hready,
  input  logic [NSTAT-1:0] status_in,
  input  logic [15:0]      ro_in,
  output logic [15:0]      ctrl_out,
  output logic [NSTRB-1:0] pulse_out,
  output logic             sram_req,
  output logic             sram_we,
  output logic [SAW-1:0]   sram_addr,
  output logic [15:0]      sram_wdata,
  input  logic [15:0]      sram_rdata,
  input  logic             sram_ack
);
  localparam logic [14:0] W_CTRL = 15'h0000;
  localparam logic [14:0] W_STAT = 15'h0001;
  localparam logic [14:0] W_RO   = 15'h0002;
  localparam logic [14:0] W_STRB = 15'h0003;
  localparam logic [14:0] W_PAGE = 15'h0018;

  logic [15:0]      ctrl_q, rdata_q, reg_rd;
  logic [NSTAT-1:0] flag_q, flag_clr;
  logic [PAGEW-1:0] page_q;
  logic [NSTRB-1:0] pulse_q;
  logic             ready_q;

  wire reg_acc = hreq & ~hsel_ext & ~ready_q;
  wire reg_wr  = reg_acc & hwe;
  wire ext_done = sram_req & sram_ack;

  assign sram_req   = hreq & hsel_ext & ~ready_q;
  assign sram_we    = hwe;
  assign sram_addr  = {page_q, haddr};
  assign sram_wdata = hwdata;
  assign hrdata     = rdata_q;
  assign hready     = ready_q;
  assign ctrl_out   = ctrl_q;
  assign pulse_out  = pulse_q;
  assign flag_clr   = (reg_wr && haddr == W_STAT) ? hwdata[NSTAT-1:0] : '0;

  always_comb begin
    case (haddr)
      W_CTRL:  reg_rd = ctrl_q;
      W_STAT:  reg_rd = 16'(flag_q);
      W_RO:    reg_rd = ro_in;
      W_PAGE:  reg_rd = 16'(page_q);
      default: reg_rd = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      flag_q  <= '0;
      page_q  <= '0;
      pulse_q <= '0;
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= reg_acc | ext_done;
      if (reg_acc && !hwe)       rdata_q <= reg_rd;
      else if (ext_done && !hwe) rdata_q <= sram_rdata;
      else                       rdata_q <= '0;
      if (reg_wr && haddr == W_CTRL) ctrl_q <= hwdata;
      if (reg_wr && haddr == W_PAGE) page_q <= hwdata[PAGEW-1:0];
      flag_q  <= (flag_q & ~flag_clr) | status_in;
      pulse_q <= (reg_wr && haddr == W_STRB) ? hwdata[NSTRB-1:0] : '0;
    end
  end

  assert_region_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hreq && !hsel_ext) |-> !sram_req);
  assert_flag_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_in != '0) |=> ((flag_q & $past(status_in)) == $past(status_in)));
  assert_strobe_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_out != '0) |=> (pulse_out == '0));
  assert_ext_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_req && sram_ack && !hwe) |=> (hready && hrdata == $past(sram_rdata)));
  assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hready |=> !hready);
endmodule

// File: tb/host_page_regif_test.sv
module host_page_regif_test;
  logic        clk = 0, rst_n = 0;
  logic        hreq = 0, hsel_ext = 0, hwe = 0;
  logic [15:1] haddr = '0;
  logic [15:0] hwdata = '0, hrdata;
  logic        hready;
  logic [7:0]  status_in = '0;
  logic [15:0] ro_in = '0, ctrl_out;
  logic [3:0]  pulse_out;
  logic        sram_req, sram_we, sram_ack = 0;
  logic [19:0] sram_addr;
  logic [15:0] sram_wdata, sram_rdata = '0;

  int checks = 0, errors = 0, cyc = 0, r1_bad = 0, ext_reqs = 0, last_lat = 0, cnt = 0;
  logic [3:0]  last_pulse;
  logic [19:0] rec_addr;
  logic        rec_we;
  logic [15:0] rec_data;
  logic [15:0] mem [int];
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  host_page_regif uut (.*);

  function automatic logic [15:0] dflt(logic [19:0] a);
    return a[15:0] ^ 16'h5A5A;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      sram_ack <= 0; cnt = 0;
    end else if (sram_ack) sram_ack <= 0;
    else if (sram_req) begin
      if (cnt == 1) begin
        cnt = 0; ext_reqs++;
        sram_ack <= 1;
        rec_addr = sram_addr; rec_we = sram_we; rec_data = sram_wdata;
        if (sram_we) mem[int'(sram_addr)] = sram_wdata;
        sram_rdata <= mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : dflt(sram_addr);
      end else cnt++;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (hreq && !hsel_ext && sram_req) r1_bad++;
    if (rst_n && hready) begin
      if (exp_q.size() == 0) chk("R11 unexpected hready", 1, 0);
      else chk(tag_q.pop_front(), hrdata, exp_q.pop_front());
    end
  end

  task automatic acc(bit ext, logic [15:0] baddr, bit we, logic [15:0] wd,
                     logic [15:0] exp, string tag);
    int lat = 0;
    @(negedge clk);
    hsel_ext = ext; haddr = baddr[15:1]; hwe = we; hwdata = wd; hreq = 1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    do begin @(negedge clk); lat++; end while (!hready);
    last_lat = lat; last_pulse = pulse_out; hreq = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        chk("watchdog", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 hready", hready, 0);
    chk("R10 ctrl_out", ctrl_out, 0);
    chk("R10 pulse_out", pulse_out, 0);
    chk("R10 sram_req", sram_req, 0);
    rst_n = 1;
    acc(0, 16'h0030, 0, 0, 16'h0000, "R10 page reset");
    acc(0, 16'h0002, 0, 0, 16'h0000, "R10 flags reset");
    acc(0, 16'h0000, 0, 0, 16'h0000, "R10 ctrl reset");
    chk("R11 register latency", last_lat, 1);

    acc(0, 16'h0000, 1, 16'hA5C3, 16'h0000, "R11 write data zero");
    acc(0, 16'h0000, 0, 0, 16'hA5C3, "R2 ctrl readback");
    chk("R2 ctrl_out", ctrl_out, 16'hA5C3);

    @(negedge clk) status_in = 8'h05;
    @(negedge clk) status_in = 8'h00;
    acc(0, 16'h0002, 0, 0, 16'h0005, "R3 flags held");
    status_in = 8'h04;
    acc(0, 16'h0002, 1, 16'h0005, 16'h0000, "R4 w1c write");
    status_in = 8'h00;
    acc(0, 16'h0002, 0, 0, 16'h0004, "R4 active flag survives clear");
    acc(0, 16'h0002, 1, 16'h0000, 16'h0000, "R4 zero write");
    acc(0, 16'h0002, 0, 0, 16'h0004, "R4 zero write no effect");
    acc(0, 16'h0002, 1, 16'h0004, 16'h0000, "R4 clear");
    acc(0, 16'h0002, 0, 0, 16'h0000, "R4 cleared");

    ro_in = 16'h3C5A;
    acc(0, 16'h0004, 0, 0, 16'h3C5A, "R5 ro read");
    acc(0, 16'h0004, 1, 16'hFFFF, 16'h0000, "R5 ro write");
    acc(0, 16'h0004, 0, 0, 16'h3C5A, "R5 ro unchanged");
    acc(0, 16'h0000, 0, 0, 16'hA5C3, "R5 ctrl untouched");

    acc(0, 16'h0006, 1, 16'h0009, 16'h0000, "R6 strobe write");
    chk("R6 pulse value", last_pulse, 4'h9);
    @(negedge clk) chk("R6 pulse one cycle", pulse_out, 4'h0);
    acc(0, 16'h0006, 0, 0, 16'h0000, "R6 reads zero");

    acc(0, 16'h0030, 1, 16'hFFFF, 16'h0000, "R7 page write");
    acc(0, 16'h0030, 0, 0, 16'h001F, "R7 page readback");
    acc(0, 16'h0030, 1, 16'h000B, 16'h0000, "R7 page write");

    acc(1, 16'h1234, 1, 16'hBEEF, 16'h0000, "R8 ext write");
    chk("R8 sram_addr", rec_addr, {5'h0B, 15'h091A});
    chk("R8 sram_we", rec_we, 1);
    chk("R8 sram_wdata", rec_data, 16'hBEEF);
    acc(1, 16'h1234, 0, 0, 16'hBEEF, "R8 ext readback");
    acc(0, 16'h0030, 1, 16'h0003, 16'h0000, "R7 page change");
    acc(1, 16'h1234, 0, 0, dflt({5'h03, 15'h091A}), "R8 other page read");
    chk("R8 other page addr", rec_addr, {5'h03, 15'h091A});
    acc(1, 16'hFFFE, 0, 0, dflt({5'h03, 15'h7FFF}), "R8 top of page");

    acc(0, 16'h0010, 1, 16'hFFFF, 16'h0000, "R9 reserved write");
    acc(0, 16'h0010, 0, 0, 16'h0000, "R9 reserved read");
    acc(0, 16'h0000, 0, 0, 16'hA5C3, "R9 ctrl intact");
    acc(0, 16'h0030, 0, 0, 16'h0003, "R9 page intact");
    acc(0, 16'hFFFE, 0, 0, 16'h0000, "R9 top reserved read");

    chk("R1 no sram on register access", r1_bad, 0);
    chk("R1 window requests", ext_reqs, 4);
    repeat (3) @(negedge clk);
    chk("R11 scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule